// File: doc/BRIEF.md
# Outbound Address Translator with Viewport Access

This block turns request addresses from the processor side into bus-side addresses. It holds a small, parameterised set of outbound regions. Each region has a 64-bit base, a 32-bit inclusive upper limit, a 64-bit target, a transaction type and an enable. Software never addresses a region directly. It first writes a viewport register that picks the direction and the region number. The region registers at the fixed offsets that follow then act on the chosen region.

The lookup is purely combinational. Every region compares the incoming address against its window. The lowest-numbered region that hits wins. Its translated address, which is the target plus the offset of the request inside the window, is presented together with the region's type code and a hit flag. For configuration types, software places the bus, device and function numbers in the target. The request offset then lands beneath them.

Top module: `atu_outbound_xlat`

## Requirements
- R1: After reset, every region is disabled, `xlat_hit` is 0 for any address, and the viewport (offset 0x900) reads back as 0.
- R2: A write to offset 0x900 stores bit 31 as the direction (1 = inbound, 0 = outbound) and the low four bits as the region number. Both read back at the same bit positions, and all other bits read 0.
- R3: With an outbound viewport on a present region, the region fields are written and read back at these offsets: 0x904 type (bits 4:0), 0x908 enable (bit 31), 0x90C/0x910 base low/high, 0x914 limit, and 0x918/0x91C target low/high.
- R4: While the viewport selects inbound, writes to offsets 0x904 to 0x91C change no region and reads of them return 0.
- R5: While the viewport names a region number at or above `NUM_REGIONS`, writes to offsets 0x904 to 0x91C change no region and reads of them return 0.
- R6: A region hits when it is enabled, `req_addr[63:32]` equals the base high word, and `req_addr[31:0]` lies between the base low word and the limit, with both bounds inclusive.
- R7: The translated address is the 64-bit sum of the target and (`req_addr[31:0]` minus the base low word). A carry propagates into the high word.
- R8: `xlat_kind` carries the winning region's type code: 0 memory, 2 I/O, 4 config type 0, 5 config type 1.
- R9: When several regions hit, the one with the lowest region number supplies the outputs.
- R10: On a miss, `xlat_hit`, `xlat_addr` and `xlat_kind` are all 0.
- R11: Writing 0 to bit 31 of offset 0x908 disables the selected region, and that region stops hitting.
- R12: A config target holding bus in bits 31:24, device in bits 23:19 and function in bits 18:16 appears unchanged in the translated address when the request sits at the region base.
- R13: A register write changes the lookup result only after the clock edge that takes the write. Before that edge, the old region contents still decide the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_addr | input | 64 | Request address to translate |
| xlat_addr | output | 64 | Translated bus-side address |
| xlat_kind | output | 5 | Transaction type code of the winning region |
| xlat_hit | output | 1 | A region covers `req_addr` |

## Verification
The lookup and a register write can fall in the same cycle. Software may reprogram a region while a request that the region covers is still on `req_addr`. The bench holds such a request steady and raises a write that changes the region's target or enable. It samples the outputs before the clock edge, where the old translation must still show, and again after the edge, where the new one must show. Overlapping windows, inclusive bounds and carry into the high word are checked with directed values whose results are worked out by hand.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int ADDR_W = 64;
  localparam int REG_W  = 32;
  localparam int KIND_W = 5;
  localparam int OFF_W  = 12;

  // register offsets decoded by software
  localparam logic [OFF_W-1:0] OFF_VIEW   = 12'h900;
  localparam logic [OFF_W-1:0] OFF_KIND   = 12'h904;
  localparam logic [OFF_W-1:0] OFF_ENA    = 12'h908;
  localparam logic [OFF_W-1:0] OFF_BASE_L = 12'h90C;
  localparam logic [OFF_W-1:0] OFF_BASE_H = 12'h910;
  localparam logic [OFF_W-1:0] OFF_LIMIT  = 12'h914;
  localparam logic [OFF_W-1:0] OFF_TGT_L  = 12'h918;
  localparam logic [OFF_W-1:0] OFF_TGT_H  = 12'h91C;

  typedef enum logic [KIND_W-1:0] {
    KIND_MEM  = 5'd0,
    KIND_IO   = 5'd2,
    KIND_CFG0 = 5'd4,
    KIND_CFG1 = 5'd5
  } kind_e;

  typedef struct packed {
    logic              en;
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] base;
    logic [REG_W-1:0]  limit;
    logic [ADDR_W-1:0] target;
  } window_t;
endpackage

// File: rtl/atu_window_bank.sv
module atu_window_bank
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int VIEW_IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OFF_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output window_t          win_q [NUM_REGIONS]
);
  logic                  view_dir_q, view_dir_n;
  logic [VIEW_IDX_W-1:0] view_idx_q, view_idx_n;
  logic                  view_wr;
  logic                  sel_ok;
  logic                  field_hit;
  window_t               cur, upd;
  logic [NUM_REGIONS-1:0] win_wr;

  assign view_wr   = we && (addr == OFF_VIEW);
  assign sel_ok    = !view_dir_q &&
                     ({1'b0, view_idx_q} < (VIEW_IDX_W+1)'(NUM_REGIONS));
  assign field_hit = (addr >= OFF_KIND) && (addr <= OFF_TGT_H) && (addr[1:0] == 2'b00);

  // viewport next state
  always_comb begin
    view_dir_n = view_dir_q;
    view_idx_n = view_idx_q;
    if (view_wr) begin
      view_dir_n = wdata[31];
      view_idx_n = wdata[VIEW_IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_dir_q <= 1'b0;
      view_idx_q <= '0;
    end else if (view_wr) begin
      view_dir_q <= view_dir_n;
      view_idx_q <= view_idx_n;
    end
  end

  // selected window and its updated copy
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (view_idx_q == VIEW_IDX_W'(i)) cur = win_q[i];
    upd = cur;
    case (addr)
      OFF_KIND:   upd.kind          = wdata[KIND_W-1:0];
      OFF_ENA:    upd.en            = wdata[31];
      OFF_BASE_L: upd.base[31:0]    = wdata;
      OFF_BASE_H: upd.base[63:32]   = wdata;
      OFF_LIMIT:  upd.limit         = wdata;
      OFF_TGT_L:  upd.target[31:0]  = wdata;
      OFF_TGT_H:  upd.target[63:32] = wdata;
      default:    upd = cur;
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
      assign win_wr[g] = we && sel_ok && field_hit && (view_idx_q == VIEW_IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         win_q[g] <= '0;
        else if (win_wr[g]) win_q[g] <= upd;
      end

      // R4
      inbound_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && field_hit && view_dir_q) |=> $stable(win_q[g]));
      // R5
      absent_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && field_hit && ({1'b0, view_idx_q} >= (VIEW_IDX_W+1)'(NUM_REGIONS))) |=> $stable(win_q[g]));
    end
  endgenerate

  // readback
  always_comb begin
    rdata = '0;
    if (addr == OFF_VIEW) begin
      rdata[31]             = view_dir_q;
      rdata[VIEW_IDX_W-1:0] = view_idx_q;
    end else if (sel_ok) begin
      case (addr)
        OFF_KIND:   rdata[KIND_W-1:0] = cur.kind;
        OFF_ENA:    rdata[31]         = cur.en;
        OFF_BASE_L: rdata = cur.base[31:0];
        OFF_BASE_H: rdata = cur.base[63:32];
        OFF_LIMIT:  rdata = cur.limit;
        OFF_TGT_L:  rdata = cur.target[31:0];
        OFF_TGT_H:  rdata = cur.target[63:32];
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/atu_window_match.sv
module atu_window_match
  import atu_pkg::*;
(
  input  window_t           win,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  logic [31:0] offset;

  assign offset = addr[31:0] - win.base[31:0];
  assign hit    = win.en &&
                  (addr[63:32] == win.base[63:32]) &&
                  (addr[31:0] >= win.base[31:0]) &&
                  (addr[31:0] <= win.limit);
  assign xaddr  = win.target + {32'b0, offset};
endmodule

// File: rtl/atu_priority_pick.sv
module atu_priority_pick
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] hits,
  input  logic [ADDR_W-1:0]      xaddrs [NUM_REGIONS],
  input  logic [KIND_W-1:0]      kinds  [NUM_REGIONS],
  output logic                   hit,
  output logic [ADDR_W-1:0]      xaddr,
  output logic [KIND_W-1:0]      kind,
  output logic [SEL_W-1:0]       sel
);
  always_comb begin
    hit   = 1'b0;
    xaddr = '0;
    kind  = '0;
    sel   = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        hit   = 1'b1;
        xaddr = xaddrs[i];
        kind  = kinds[i];
        sel   = SEL_W'(i);
      end
    end
  end

  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hits & ((NUM_REGIONS)'(1) << sel) - (NUM_REGIONS)'(1)) == '0) && hits[sel]);
  // R10
  miss_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |-> (!hit && xaddr == '0 && kind == '0));
endmodule

// File: rtl/atu_outbound_xlat.sv
module atu_outbound_xlat
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int VIEW_IDX_W  = 4,
  localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [63:0] req_addr,
  output logic [63:0] xlat_addr,
  output logic [4:0]  xlat_kind,
  output logic        xlat_hit
);
  logic [1:0]             rst_sync_q;
  logic                   rst_int_n;
  window_t                win_q  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hits;
  logic [ADDR_W-1:0]      xaddrs [NUM_REGIONS];
  logic [KIND_W-1:0]      kinds  [NUM_REGIONS];
  logic [SEL_W-1:0]       sel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  atu_window_bank #(.NUM_REGIONS(NUM_REGIONS), .VIEW_IDX_W(VIEW_IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .win_q (win_q)
  );

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      atu_window_match u_match (
        .win   (win_q[g]),
        .addr  (req_addr),
        .hit   (hits[g]),
        .xaddr (xaddrs[g])
      );
      assign kinds[g] = win_q[g].kind;
    end
  endgenerate

  atu_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hits   (hits),
    .xaddrs (xaddrs),
    .kinds  (kinds),
    .hit    (xlat_hit),
    .xaddr  (xlat_addr),
    .kind   (xlat_kind),
    .sel    (sel)
  );

  // R6
  winner_covers_request_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    xlat_hit |-> (win_q[sel].en &&
                  req_addr[31:0] >= win_q[sel].base[31:0] &&
                  req_addr[31:0] <= win_q[sel].limit));
  // R8
  kind_from_winner_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    xlat_hit |-> (xlat_kind == win_q[sel].kind));
endmodule

// File: tb/tb_atu_outbound_xlat.sv
`timescale 1ns/1ps
module tb_atu_outbound_xlat;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [63:0] req_addr;
  logic [63:0] xlat_addr;
  logic [4:0]  xlat_kind;
  logic        xlat_hit;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  atu_outbound_xlat dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .xlat_addr(xlat_addr), .xlat_kind(xlat_kind), .xlat_hit(xlat_hit)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata === exp, tag, {32'b0, cfg_rdata}, {32'b0, exp});
  endtask

  task automatic look_chk(input logic [63:0] a, input bit eh, input logic [63:0] ea,
                          input logic [4:0] ek, input string tag);
    @(negedge clk);
    req_addr = a;
    #1;
    check(xlat_hit === eh, {tag, " hit"}, {63'b0, xlat_hit}, {63'b0, eh});
    check(xlat_addr === ea, {tag, " addr"}, xlat_addr, ea);
    check(xlat_kind === ek, {tag, " kind"}, {59'b0, xlat_kind}, {59'b0, ek});
  endtask

  task automatic prog(input int idx, input logic [4:0] k, input logic [63:0] b,
                      input logic [31:0] lim, input logic [63:0] t, input bit en);
    wr(12'h900, 32'(idx));
    wr(12'h904, {27'b0, k});
    wr(12'h90C, b[31:0]);
    wr(12'h910, b[63:32]);
    wr(12'h914, lim);
    wr(12'h918, t[31:0]);
    wr(12'h91C, t[63:32]);
    wr(12'h908, {en, 31'b0});
  endtask

  task automatic t_reset();
    look_chk(64'h0, 1'b0, 64'h0, 5'd0, "R1 reset");
    rd_chk(12'h900, 32'h0, "R1 view after reset");
    rd_chk(12'h908, 32'h0, "R1 region0 disabled");
  endtask

  task automatic t_view_fields();
    wr(12'h900, 32'h8000_0003);
    rd_chk(12'h900, 32'h8000_0003, "R2 view dir+idx");
    wr(12'h900, 32'h7FFF_FFF1);
    rd_chk(12'h900, 32'h0000_0001, "R2 view other bits");
    prog(0, 5'd0, 64'h0000_0001_1000_0000, 32'h1000_FFFF, 64'h0000_0000_8000_0000, 1'b1);
    rd_chk(12'h904, 32'h0, "R3 kind r0");
    rd_chk(12'h90C, 32'h1000_0000, "R3 base lo");
    rd_chk(12'h910, 32'h0000_0001, "R3 base hi");
    rd_chk(12'h914, 32'h1000_FFFF, "R3 limit");
    rd_chk(12'h918, 32'h8000_0000, "R3 target lo");
    rd_chk(12'h91C, 32'h0, "R3 target hi");
    rd_chk(12'h908, 32'h8000_0000, "R3 enable");
    prog(1, 5'd2, 64'h0000_0001_1000_8000, 32'h1001_FFFF, 64'h0000_0002_0000_0000, 1'b1);
    rd_chk(12'h904, 32'h2, "R3 kind r1");
  endtask

  task automatic t_lookup();
    look_chk(64'h0000_0001_1000_0000, 1'b1, 64'h0000_0000_8000_0000, 5'd0, "R6 low bound");
    look_chk(64'h0000_0001_1000_0FFF, 1'b1, 64'h0000_0000_8000_0FFF, 5'd0, "R7 offset");
    look_chk(64'h0000_0001_0FFF_FFFF, 1'b0, 64'h0, 5'd0, "R10 below base");
    look_chk(64'h0000_0002_1000_0000, 1'b0, 64'h0, 5'd0, "R6 high word mismatch");
    look_chk(64'h0000_0001_1000_8000, 1'b1, 64'h0000_0000_8000_8000, 5'd0, "R9 overlap lowest");
    look_chk(64'h0000_0001_1001_0000, 1'b1, 64'h0000_0002_0000_8000, 5'd2, "R8 io region1");
    look_chk(64'h0000_0001_1001_FFFF, 1'b1, 64'h0000_0002_0001_7FFF, 5'd2, "R6 limit inclusive");
    look_chk(64'h0000_0001_1002_0000, 1'b0, 64'h0, 5'd0, "R10 above limit");
  endtask

  task automatic t_ignored();
    wr(12'h900, 32'h8000_0000);
    wr(12'h918, 32'hDEAD_BEEF);
    rd_chk(12'h918, 32'h0, "R4 inbound read zero");
    wr(12'h900, 32'h0000_0000);
    rd_chk(12'h918, 32'h8000_0000, "R4 inbound write ignored");
    wr(12'h900, 32'h0000_0005);
    wr(12'h908, 32'h0);
    rd_chk(12'h908, 32'h0, "R5 absent read zero");
    look_chk(64'h0000_0001_1000_0010, 1'b1, 64'h0000_0000_8000_0010, 5'd0, "R5 absent write ignored");
  endtask

  task automatic t_same_cycle();
    wr(12'h900, 32'h0);
    @(negedge clk);
    req_addr = 64'h0000_0001_1000_0004;
    cfg_we = 1'b1; cfg_addr = 12'h918; cfg_wdata = 32'h4000_0000;
    #1;
    check(xlat_addr === 64'h0000_0000_8000_0004, "R13 before edge", xlat_addr, 64'h0000_0000_8000_0004);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check(xlat_addr === 64'h0000_0000_4000_0004, "R13 after edge", xlat_addr, 64'h0000_0000_4000_0004);
    wr(12'h908, 32'h0);
    look_chk(64'h0000_0001_1000_9000, 1'b1, 64'h0000_0002_0000_1000, 5'd2, "R11 r0 off r1 takes");
    look_chk(64'h0000_0001_1000_0004, 1'b0, 64'h0, 5'd0, "R11 disabled miss");
  endtask

  task automatic t_carry_cfg();
    prog(1, 5'd5, 64'h0000_0000_2000_0000, 32'h2000_FFFF, 64'h0000_0003_FFFF_FFF0, 1'b1);
    look_chk(64'h0000_0000_2000_0020, 1'b1, 64'h0000_0004_0000_0010, 5'd5, "R7 carry");
    prog(0, 5'd4, 64'h0000_0000_3000_0000, 32'h3000_0FFF, 64'h0000_0000_5A4B_0000, 1'b1);
    look_chk(64'h0000_0000_3000_0000, 1'b1, 64'h0000_0000_5A4B_0000, 5'd4, "R12 cfg bdf");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_view_fields();
    t_lookup();
    t_ignored();
    t_same_cycle();
    t_carry_cfg();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule